// File: doc/BRIEF.md
# ISA Bus Clock Divider and I/O Recovery Timer

This block derives the ISA bus clock from the 33 MHz LPC clock and enforces a minimum idle time between back-to-back ISA I/O commands. Each ISA cycle can run at a different speed. A normal cycle divides the LPC clock by 3 or 4. A fast cycle divides it by 2 or by 1. A fast cycle is selected by a global bit or by an address-decoder hit whose fast enable is set. A power-down code can slow the ISA clock further by a power of two, or it can ask the surrounding logic to float every clock and bus signal.

The clock is produced as a phase counter. From it come three outputs: a level, a one-cycle pulse at each rising edge, and a one-cycle pulse at each falling edge. A new divide ratio is only taken up once the current low phase ends. As a result, no shortened high or low phase ever appears on the bus.

The recovery timer counts ISA clock half-periods, that is, both rising and falling edges. The count starts at the end-of-cycle strobe. The timer holds the next I/O command back until 7 plus twice the configured extra clocks have passed. This gives an exact 3.5-clock base whatever the divide ratio. The divider and recovery settings sit in one configuration byte that loads through a write strobe.

Top module: `isa_clk_recovery`

## Requirements
- R1: After reset the configuration byte is 0x4D. The divider therefore runs at divide-by-4, `rec_done` is 1 and `tristate_req` is 0.
- R2: In normal mode the ISA clock period is 4 LPC clocks when configuration bit 7 is 0, and 3 when it is 1. The high phase lasts floor(period/2) clocks and starts in the cycle where `sysclk_rise` pulses. At period 1, `sysclk` stays high and both edge pulses fire every cycle.
- R3: A cycle is fast when any of these holds: `fast_all` is set, `dec1_hit` and `dec1_fast` are both set, or `dec2_hit` and `dec2_fast` are both set. A fast cycle has a base period of 2 when `fast_div1` is 0, and 1 when it is 1.
- R4: A `pd_code` value k from 1 to 6 multiplies the base period by 2^k. A code of 0 leaves the base period unchanged.
- R5: A `pd_code` of 7 raises `tristate_req` and applies no extra division.
- R6: A change of period takes effect only at the end of a low phase. The period in progress completes at its old length.
- R7: `rec_done` is 0 from the cycle after an `cyc_end` strobe. It returns to 1 in the cycle after the ISA clock edges counted since the strobe reach N. N is 7 + 2*E half-periods, where E is the number of extra clocks.
- R8: For 8-bit cycles (`cyc_is16` = 0), E is configuration bits 5:3 when bit 6 is 1, and 0 when bit 6 is 0.
- R9: For 16-bit cycles (`cyc_is16` = 1), E depends on configuration bit 2. When bit 2 is 1, bits 1:0 give E: 01 is 1, 10 is 2, 11 is 3 and 00 is 4. When bit 2 is 0, E is 0.
- R10: When `cfg_we` is high at a clock edge, `cfg_wdata` replaces the configuration byte, and the new value governs the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte write value |
| fast_all | input | 1 | Global fast mode |
| fast_div1 | input | 1 | Fast ratio select: 0 = divide by 2, 1 = divide by 1 |
| dec1_hit | input | 1 | Address decoder 1 matched the current cycle |
| dec1_fast | input | 1 | Fast enable for decoder 1 |
| dec2_hit | input | 1 | Address decoder 2 matched the current cycle |
| dec2_fast | input | 1 | Fast enable for decoder 2 |
| pd_code | input | 3 | Power-down divide code |
| cyc_is16 | input | 1 | Cycle ending now is a 16-bit I/O cycle |
| cyc_end | input | 1 | End-of-cycle strobe |
| sysclk | output | 1 | ISA clock level |
| sysclk_rise | output | 1 | Pulse in the first cycle of the high phase |
| sysclk_fall | output | 1 | Pulse in the first cycle of the low phase |
| rec_done | output | 1 | Recovery complete, next I/O command may start |
| tristate_req | output | 1 | Request to float all clocks and bus signals |

## Verification
The bench builds the block with its default reset byte of 0x4D, so the reset-state checks see divide-by-4 and a 9-half-period recovery for both cycle widths. Power-down codes up to 6 are reachable, so the longest period of 256 LPC clocks is measured directly. Random codes are kept to 0 to 3, which lets many mixes of fast, normal and prescaled periods fit in the run. Recovery is checked cycle by cycle against the edges seen at the ports. This covers the period-1 case, where two half-periods expire in one cycle.

// File: rtl/isa_clk_pkg.sv
package isa_clk_pkg;
  localparam int unsigned RATIO_MAX   = 4;
  localparam int unsigned PRE_MAX_LOG = 6;
  localparam int unsigned PD_W        = 3;
  localparam int unsigned PER_W       = $clog2(RATIO_MAX << PRE_MAX_LOG) + 1;
  localparam int unsigned BASE_HALVES = 7;
  localparam int unsigned EXTRA_MAX   = 7;
  localparam int unsigned HALF_MAX    = BASE_HALVES + 2 * EXTRA_MAX;
  localparam int unsigned HALF_W      = $clog2(HALF_MAX + 1);

  // configuration byte, msb first: bit7 div3, bit6 8-bit enable, 5:3 8-bit extra,
  // bit2 16-bit enable, 1:0 16-bit extra
  typedef struct packed {
    logic       div3;
    logic       rec8_en;
    logic [2:0] rec8_add;
    logic       rec16_en;
    logic [1:0] rec16_add;
  } cfg_t;

  function automatic logic [2:0] base_ratio(input logic fast, input logic div1, input logic div3);
    if (fast) return div1 ? 3'd1 : 3'd2;
    return div3 ? 3'd3 : 3'd4;
  endfunction

  function automatic logic [PER_W-1:0] full_period(input logic [2:0] ratio, input logic [PD_W-1:0] pd);
    logic [PER_W-1:0] p;
    p = PER_W'(ratio);
    if (pd != '0 && pd != '1) p = p << pd;
    return p;
  endfunction

  function automatic logic [HALF_W-1:0] rec_halves(input cfg_t c, input logic is16);
    logic [2:0] extra;
    extra = 3'd0;
    if (is16) begin
      if (c.rec16_en) extra = (c.rec16_add == 2'b00) ? 3'd4 : {1'b0, c.rec16_add};
    end else if (c.rec8_en) begin
      extra = c.rec8_add;
    end
    return HALF_W'(BASE_HALVES) + HALF_W'({extra, 1'b0});
  endfunction
endpackage

// File: rtl/isa_clk_div.sv
module isa_clk_div import isa_clk_pkg::*; #(
  parameter logic [PER_W-1:0] RST_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] next_period,
  output logic             sys_rise,
  output logic             sys_fall,
  output logic             sys_lvl,
  output logic [1:0]       edge_cnt
);
  logic [PER_W-1:0] ph;
  logic [PER_W-1:0] cur;
  logic [PER_W-1:0] half;
  logic             wrap;

  assign half = cur >> 1;
  assign wrap = (ph == cur - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= '0;
      cur <= RST_PERIOD;
    end else if (wrap) begin
      ph  <= '0;
      cur <= next_period;
    end else begin
      ph  <= ph + PER_W'(1);
    end
  end

  assign sys_rise = (ph == '0);
  assign sys_fall = (ph == half);
  assign sys_lvl  = (cur == PER_W'(1)) ? 1'b1 : (ph < half);
  assign edge_cnt = {1'b0, sys_rise} + {1'b0, sys_fall};

  // R6
  hold_period_chk: assert property (@(posedge clk) disable iff (!rst_n) !wrap |=> $stable(cur));
  // R2
  restart_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> sys_rise);
  // R2
  dual_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rise && sys_fall) |-> (cur == PER_W'(1)));
endmodule

// File: rtl/isa_rec_timer.sv
module isa_rec_timer import isa_clk_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_end,
  input  logic [HALF_W-1:0] load_val,
  input  logic [1:0]        edges,
  output logic              rec_done
);
  logic [HALF_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (cyc_end)       cnt <= load_val;
    else if (cnt != '0)     cnt <= (cnt <= HALF_W'(edges)) ? '0 : cnt - HALF_W'(edges);
  end

  assign rec_done = (cnt == '0);

  // R7
  strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) cyc_end |=> !rec_done);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= HALF_W'(HALF_MAX));
  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_done) |-> $past(edges != 2'd0));
endmodule

// File: rtl/isa_clk_recovery.sv
module isa_clk_recovery import isa_clk_pkg::*; #(
  parameter logic [7:0] CFG_RST = 8'h4D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_wdata,
  input  logic            fast_all,
  input  logic            fast_div1,
  input  logic            dec1_hit,
  input  logic            dec1_fast,
  input  logic            dec2_hit,
  input  logic            dec2_fast,
  input  logic [PD_W-1:0] pd_code,
  input  logic            cyc_is16,
  input  logic            cyc_end,
  output logic            sysclk,
  output logic            sysclk_rise,
  output logic            sysclk_fall,
  output logic            rec_done,
  output logic            tristate_req
);
  localparam logic [PER_W-1:0] RST_PERIOD = full_period(base_ratio(1'b0, 1'b0, CFG_RST[7]), '0);

  cfg_t              cfg_q;
  logic              fast_hit;
  logic [2:0]        ratio;
  logic [PER_W-1:0]  next_period;
  logic [HALF_W-1:0] load_halves;
  logic [1:0]        edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= cfg_t'(CFG_RST);
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  assign fast_hit     = fast_all | (dec1_hit & dec1_fast) | (dec2_hit & dec2_fast);
  assign ratio        = base_ratio(fast_hit, fast_div1, cfg_q.div3);
  assign next_period  = full_period(ratio, pd_code);
  assign load_halves  = rec_halves(cfg_q, cyc_is16);
  assign tristate_req = (pd_code == '1);

  isa_clk_div #(.RST_PERIOD(RST_PERIOD)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .next_period (next_period),
    .sys_rise    (sysclk_rise),
    .sys_fall    (sysclk_fall),
    .sys_lvl     (sysclk),
    .edge_cnt    (edge_cnt)
  );

  isa_rec_timer u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_end  (cyc_end),
    .load_val (load_halves),
    .edges    (edge_cnt),
    .rec_done (rec_done)
  );
endmodule

// File: tb/isa_clk_recovery_tb.sv
`timescale 1ns/1ps
module isa_clk_recovery_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [7:0] cfg_wdata = 0;
  logic fast_all = 0, fast_div1 = 0, dec1_hit = 0, dec1_fast = 0, dec2_hit = 0, dec2_fast = 0;
  logic [2:0] pd_code = 0;
  logic cyc_is16 = 0, cyc_end = 0;
  logic sysclk, sysclk_rise, sysclk_fall, rec_done, tristate_req;
  logic [7:0] cfg_sh = 8'h4D;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  isa_clk_recovery u_dut (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_period();
    int r;
    bit fm;
    fm = fast_all || (dec1_hit && dec1_fast) || (dec2_hit && dec2_fast);
    if (fm) r = fast_div1 ? 1 : 2;
    else    r = cfg_sh[7] ? 3 : 4;
    if (pd_code >= 1 && pd_code <= 6) r = r * (2 ** int'(pd_code));
    return r;
  endfunction

  function automatic int exp_halves(bit is16);
    int x = 0;
    if (is16) begin
      if (cfg_sh[2]) x = (cfg_sh[1:0] == 2'b00) ? 4 : int'(cfg_sh[1:0]);
    end else if (cfg_sh[6]) x = int'(cfg_sh[5:3]);
    return 7 + 2 * x;
  endfunction

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0; cfg_sh = v;
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!sysclk_rise);
  endtask

  task automatic get_period(output int p, output int h);
    wait_rise();
    p = 0; h = 0;
    do begin
      h += int'(sysclk);
      @(negedge clk); p++;
    end while (!sysclk_rise);
  endtask

  task automatic period_test(string req);
    int p, h, ep, eh;
    ep = exp_period();
    eh = (ep == 1) ? 1 : ep / 2;
    wait_rise();
    get_period(p, h);
    chk(p == ep, req, "sysclk period", p, ep);
    chk(h == eh, req, "sysclk high width", h, eh);
  endtask

  task automatic rec_check(string req, bit is16);
    int acc, n;
    bit bad;
    n = exp_halves(is16);
    @(negedge clk); cyc_is16 = is16; cyc_end = 1;
    @(negedge clk); cyc_end = 0;
    acc = 0; bad = 0;
    for (int k = 0; k < 6000; k++) begin
      if (rec_done !== (acc >= n)) bad = 1;
      if (acc >= n) break;
      acc += int'(sysclk_rise) + int'(sysclk_fall);
      @(negedge clk);
    end
    chk(!bad && acc >= n, req, "recovery half-periods", bad ? -acc : acc, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p, h;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rec_done === 1'b1, "R1", "rec_done at reset", int'(rec_done), 1);
    chk(tristate_req === 1'b0, "R1", "tristate_req at reset", int'(tristate_req), 0);
    rst_n = 1;
    @(negedge clk);
    chk(rec_done === 1'b1, "R1", "rec_done after reset", int'(rec_done), 1);
    get_period(p, h);
    chk(p == 4, "R1", "default period", p, 4);
    rec_check("R1", 1'b0);
    rec_check("R1", 1'b1);

    // R2 normal divide by 3
    write_cfg(8'hC0);
    period_test("R2");
    write_cfg(8'h00);
    period_test("R2");

    // R3 fast selection
    dec1_hit = 1; period_test("R3");          // hit without enable: normal
    dec1_fast = 1; period_test("R3");         // fast /2
    dec1_hit = 0; dec2_hit = 1; dec2_fast = 1; period_test("R3");
    dec2_hit = 0; fast_all = 1; fast_div1 = 1; period_test("R3");   // period 1
    rec_check("R2", 1'b0);
    fast_all = 0; fast_div1 = 0; dec1_fast = 0; dec2_fast = 0;

    // R4 prescale extremes
    pd_code = 3'd6; period_test("R4");
    pd_code = 3'd1; period_test("R4");
    // R5 tristate code
    pd_code = 3'd7;
    @(negedge clk);
    chk(tristate_req === 1'b1, "R5", "tristate_req", int'(tristate_req), 1);
    period_test("R5");
    pd_code = 3'd0;
    @(negedge clk);
    chk(tristate_req === 1'b0, "R5", "tristate_req cleared", int'(tristate_req), 0);

    // R6 change mid-period
    write_cfg(8'h00);
    wait_rise(); wait_rise();
    pd_code = 3'd2;
    p = 0;
    do begin @(negedge clk); p++; end while (!sysclk_rise);
    chk(p == 4, "R6", "period in progress keeps old length", p, 4);
    get_period(p, h);
    chk(p == 16, "R6", "new period after boundary", p, 16);
    pd_code = 3'd0;

    // R8 / R9 directed recovery encodings
    write_cfg(8'h78); rec_check("R8", 1'b0);   // extra 7
    write_cfg(8'h38); rec_check("R8", 1'b0);   // enable clear
    write_cfg(8'h04); rec_check("R9", 1'b1);   // 00 -> 4
    write_cfg(8'h07); rec_check("R9", 1'b1);   // 11 -> 3
    write_cfg(8'h03); rec_check("R9", 1'b1);   // enable clear
    // R10 write takes effect
    write_cfg(8'h80);
    period_test("R10");

    // random mix
    for (int it = 0; it < 40; it++) begin
      bit is16;
      write_cfg(8'($urandom));
      fast_all  = ($urandom % 4) == 0;
      fast_div1 = 1'($urandom);
      dec1_hit  = 1'($urandom); dec1_fast = 1'($urandom);
      dec2_hit  = 1'($urandom); dec2_fast = 1'($urandom);
      pd_code   = 3'($urandom % 4);
      is16      = 1'($urandom);
      period_test("R4");
      rec_check(is16 ? "R9" : "R8", is16);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule